// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front-End

This block is the register-side front-end of a simple serial port. A processor talks to it through a word-wide register port: address, write strobe, read strobe, write data and read data. On the line side it emits one transmit byte per write to the data-out register, and it accepts received bytes into a 16-entry receive FIFO. Bit timing, framing and baud generation sit elsewhere. Transmission is treated as finishing at once, so the transmitter always reports ready and idle.

Received data is read through two status/data words. One of them returns the oldest byte and also removes it from the FIFO. The other returns the same value and leaves the FIFO unchanged. A raw interrupt word collects transmit events and the receive-not-empty condition. A mask word selects which raw bits drive the single level interrupt output. An acknowledge word clears raw bits. The first acknowledge after a transmit cannot clear raw bit 0.

Top module: `uart_regfront`

## Requirements
- R1: After a synchronous reset, the receive control word (byte offset 0x08) reads 0x0001_0000. Every other storage word, the raw interrupt word and the FIFO are clear, and `irq` is low.
- R2: A read at byte offset 0x20 or 0x24 returns the oldest FIFO byte in bits 7:0. Bit 16 is 1 when the FIFO is non-empty. Bits 22 and 24 always read 1. All other bits read 0.
- R3: A read at 0x24 leaves the FIFO unchanged. A read at 0x20 removes the oldest byte at the clock edge that samples it. A read at 0x20 on an empty FIFO has no effect.
- R4: The FIFO keeps 16 bytes in arrival order, including across index wrap. A byte that arrives while the FIFO holds 16 bytes is discarded.
- R5: A received byte (`rx_valid` high) is accepted only while bit 3 of the receive control word is 1.
- R6: Raw interrupt bit 3 is set to the FIFO non-empty state after every write inside the register window and after every accepted byte. A pop read on its own does not update it.
- R7: A write to the data-out word (0x1C) stores the value. One cycle later it pulses `tx_valid` with `tx_byte` equal to bits 7:0 of the written value. It sets raw interrupt bits 0 and 1 and sets a pending-transmit flag.
- R8: A write to the acknowledge word (0x30) clears every raw interrupt bit whose written bit is 1. If the pending-transmit flag is set, bit 0 of the written value is forced to 0 first, the flag is cleared, and the stored acknowledge word holds the altered value.
- R9: Reading 0x38 returns the raw interrupt word (0x34) AND the mask word (0x2C). `irq` is high exactly when that result is non-zero.
- R10: These words are plain read/write storage: 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x28 and 0x2C. A write to 0x34 loads the raw word, with bit 3 then recomputed. Writes to 0x20, 0x24 and 0x38 change nothing. Offsets 0x3C and above read 0 and ignore writes.
- R11: When a pop read and an accepted byte fall in the same cycle, the FIFO count is unchanged and the byte order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (needed for the pop side effect) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
Read data depends combinationally on the address and the state registered at the previous edge. The bench therefore samples `reg_rdata` a moment after it drives the address, away from any edge. State changes (pops, pushes, raw and mask updates, `irq`) show up after the edge that samples the stimulus. They are compared on the following falling edge against a behavioural model that updates on that same edge. `tx_valid` and `tx_byte` are due exactly one cycle after the write. The model produces its expected pulse from the write it saw at the previous rising edge and compares it every cycle. The status byte field is compared only while data is available, because its content is unspecified when the FIFO is empty.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_WORDS = 15;
    localparam int NUM_SLOTS = 16;

    localparam logic [3:0] WI_TXCTL   = 4'd0;
    localparam logic [3:0] WI_TXDMA   = 4'd1;
    localparam logic [3:0] WI_RXCTL   = 4'd2;
    localparam logic [3:0] WI_DOUT    = 4'd7;
    localparam logic [3:0] WI_POP     = 4'd8;
    localparam logic [3:0] WI_PEEK    = 4'd9;
    localparam logic [3:0] WI_MASK    = 4'd11;
    localparam logic [3:0] WI_ACK     = 4'd12;
    localparam logic [3:0] WI_RAW     = 4'd13;
    localparam logic [3:0] WI_MASKED  = 4'd14;

    localparam int STAT_AVAIL = 16;
    localparam int STAT_IDLE  = 22;
    localparam int STAT_RDY   = 24;
    localparam int RXEN_BIT   = 3;
    localparam int RAW_RX_BIT = 3;

    localparam logic [REG_W-1:0] RXCTL_RESET = 32'h0001_0000;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             in_win;
        logic [3:0]       word;
        logic [REG_W-1:0] data;
    } sp_req_t;

    function automatic logic is_plain_word(int idx);
        return (idx < NUM_WORDS) && (idx != int'(WI_POP)) && (idx != int'(WI_PEEK))
            && (idx != int'(WI_RAW)) && (idx != int'(WI_MASKED));
    endfunction

    function automatic logic [REG_W-1:0] word_reset(int idx);
        return (idx == int'(WI_RXCTL)) ? RXCTL_RESET : '0;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(logic avail, logic [7:0] b);
        logic [REG_W-1:0] r;
        r              = '0;
        r[7:0]         = b;
        r[STAT_AVAIL]  = avail;
        r[STAT_IDLE]   = 1'b1;
        r[STAT_RDY]    = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sp_rx_fifo.sv
module sp_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          push_ok,
    output logic          pop_ok
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign push_ok = push_req && (count < CW'(DEPTH));
    assign pop_ok  = pop_req && (count != '0);
    assign head    = mem[rd_ptr];

    always_comb begin
        count_nxt = count;
        unique case ({push_ok, pop_ok})
            2'b10:   count_nxt = count + CW'(1);
            2'b01:   count_nxt = count - CW'(1);
            default: count_nxt = count;
        endcase
    end

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nxt;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push_ok && (wr_ptr == PW'(i)))
                mem[i] <= push_data;
        end
    end

endmodule

// File: rtl/sp_word_store.sv
module sp_word_store
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       wr_word,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] words [NUM_SLOTS]
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_word
        if (is_plain_word(i)) begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    words[i] <= word_reset(i);
                else if (wr_en && (wr_word == 4'(i)))
                    words[i] <= wr_data;
            end
        end else begin : g_none
            assign words[i] = '0;
        end
    end

endmodule

// File: rtl/sp_irq_unit.sv
module sp_irq_unit
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [3:0]       word,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_accept,
    input  logic             nonempty_nxt,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] raw,
    output logic             pend,
    output logic [REG_W-1:0] ack_val,
    output logic             irq
);

    logic [REG_W-1:0] raw_n;
    logic             pend_n;

    always_comb begin
        ack_val = wdata;
        if (pend) ack_val[0] = 1'b0;
    end

    always_comb begin
        raw_n  = raw;
        pend_n = pend;
        if (wr_hit) begin
            if (word == WI_DOUT) begin
                raw_n[1:0] = 2'b11;
                pend_n     = 1'b1;
            end else if (word == WI_ACK) begin
                raw_n  = raw & ~ack_val;
                pend_n = 1'b0;
            end else if (word == WI_RAW) begin
                raw_n = wdata;
            end
        end
        if (wr_hit || rx_accept)
            raw_n[RAW_RX_BIT] = nonempty_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            pend <= 1'b0;
        end else begin
            raw  <= raw_n;
            pend <= pend_n;
        end
    end

    assign irq = |(raw & mask);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              irq
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    sp_req_t          req;
    logic [WORD_W-1:0] word_full;
    logic [3:0]       word;
    logic             in_win;
    logic [REG_W-1:0] words [NUM_SLOTS];
    logic [REG_W-1:0] rxctl, mask, raw_q, ack_val, store_data;
    logic             pend_q;
    logic [7:0]       head;
    logic [CNT_W-1:0] fifo_cnt, fifo_cnt_nxt;
    logic             push_ok, pop_ok, pop_req;

    assign word_full = reg_addr[ADDR_W-1:2];
    assign in_win    = (int'(word_full) < NUM_WORDS);
    assign word      = word_full[3:0];

    assign req = '{wr: reg_wr, rd: reg_rd, in_win: in_win, word: word, data: reg_wdata};

    assign rxctl   = words[WI_RXCTL];
    assign mask    = words[WI_MASK];
    assign pop_req = req.rd && req.in_win && (req.word == WI_POP);

    assign store_data = (req.word == WI_ACK) ? ack_val : req.data;

    sp_word_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr && req.in_win),
        .wr_word (req.word),
        .wr_data (store_data),
        .words   (words)
    );

    sp_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (rx_valid && rxctl[RXEN_BIT]),
        .push_data (rx_byte),
        .pop_req   (pop_req),
        .head      (head),
        .count     (fifo_cnt),
        .count_nxt (fifo_cnt_nxt),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok)
    );

    sp_irq_unit u_irq (
        .clk          (clk),
        .rst          (rst),
        .wr_hit       (req.wr && req.in_win),
        .word         (req.word),
        .wdata        (req.data),
        .rx_accept    (push_ok),
        .nonempty_nxt (fifo_cnt_nxt != '0),
        .mask         (mask),
        .raw          (raw_q),
        .pend         (pend_q),
        .ack_val      (ack_val),
        .irq          (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (req.in_win) begin
            unique case (req.word)
                WI_POP, WI_PEEK: reg_rdata = pack_status(fifo_cnt != '0, head);
                WI_RAW:          reg_rdata = raw_q;
                WI_MASKED:       reg_rdata = raw_q & mask;
                default:         reg_rdata = words[req.word];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= req.wr && req.in_win && (req.word == WI_DOUT);
            if (req.wr && req.in_win && (req.word == WI_DOUT))
                tx_byte <= req.data[7:0];
        end
    end

endmodule

// File: rtl/sp_regfront_chk.sv
module sp_regfront_chk #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              rx_valid,
    input logic              irq,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic [31:0]       raw_q,
    input logic              pend_q,
    input logic [31:0]       rxctl
);

    logic [ADDR_W-1:0] a_pop, a_peek, a_dout, a_ack, a_masked;
    logic              in_win;
    assign a_pop    = ADDR_W'(8'h20);
    assign a_peek   = ADDR_W'(8'h24);
    assign a_dout   = ADDR_W'(8'h1C);
    assign a_ack    = ADDR_W'(8'h30);
    assign a_masked = ADDR_W'(8'h38);
    assign in_win   = int'(reg_addr[ADDR_W-1:2]) < 15;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH)); // R4

    AST_STATUS_CONST: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:2] == a_pop[ADDR_W-1:2] || reg_addr[ADDR_W-1:2] == a_peek[ADDR_W-1:2])
        |-> (reg_rdata[24] && reg_rdata[22] && (reg_rdata[16] == (fifo_cnt != '0)))); // R2

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[ADDR_W-1:2] == a_peek[ADDR_W-1:2] && !rx_valid)
        |=> $stable(fifo_cnt)); // R3

    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rxctl[3] && !(reg_rd && reg_addr[ADDR_W-1:2] == a_pop[ADDR_W-1:2]))
        |=> $stable(fifo_cnt)); // R5

    AST_RAW_RX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && in_win) |=> (raw_q[3] == (fifo_cnt != '0))); // R6

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[ADDR_W-1:2] == a_dout[ADDR_W-1:2])
        |=> (tx_valid && tx_byte == $past(reg_wdata[7:0]))); // R7

    AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(reg_wr && reg_addr[ADDR_W-1:2] == a_dout[ADDR_W-1:2])); // R7

    AST_ACK_KEEPS_BIT0: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[ADDR_W-1:2] == a_ack[ADDR_W-1:2] && pend_q && raw_q[0])
        |=> raw_q[0]); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[ADDR_W-1:2] == a_masked[ADDR_W-1:2]) |-> ((reg_rdata != '0) == irq)); // R9

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[ADDR_W-1:2] == a_pop[ADDR_W-1:2] && rx_valid && rxctl[3]
         && fifo_cnt != '0 && fifo_cnt != CNT_W'(DEPTH)) |=> $stable(fifo_cnt)); // R11

endmodule

bind uart_regfront sp_regfront_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .rx_valid  (rx_valid),
    .irq       (irq),
    .fifo_cnt  (fifo_cnt),
    .raw_q     (raw_q),
    .pend_q    (pend_q),
    .rxctl     (rxctl)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .irq(irq)
    );

    // behavioural reference model
    logic [7:0]  q [$];
    logic [31:0] st [16];
    logic [31:0] m_raw;
    bit          m_pend;
    bit          m_txv;
    logic [7:0]  m_txb;

    function automatic bit plain(int w);
        return w < 15 && w != 8 && w != 9 && w != 13 && w != 14;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            foreach (st[i]) st[i] = '0;
            st[2]  = 32'h0001_0000;
            m_raw  = '0;
            m_pend = 0;
            m_txv  = 0;
            m_txb  = '0;
        end else begin
            int  w;
            bit  win, push, pop;
            logic [31:0] v;
            w    = int'(reg_addr[5:2]);
            win  = w < 15;
            push = rx_valid && st[2][3] && q.size() < 16;
            pop  = reg_rd && win && w == 8 && q.size() > 0;
            if (pop)  void'(q.pop_front());
            if (push) q.push_back(rx_byte);
            m_txv = reg_wr && win && w == 7;
            if (m_txv) m_txb = reg_wdata[7:0];
            if (reg_wr && win) begin
                v = reg_wdata;
                if (w == 7) begin
                    m_raw |= 32'h3;
                    m_pend = 1;
                end else if (w == 12) begin
                    if (m_pend) v[0] = 1'b0;
                    m_pend = 0;
                    m_raw &= ~v;
                end else if (w == 13) begin
                    m_raw = v;
                end
                if (plain(w)) st[w] = v;
            end
            if ((reg_wr && win) || push) m_raw[3] = (q.size() > 0);
        end
    end

    function automatic logic [31:0] mread(logic [5:0] a);
        int w = int'(a[5:2]);
        if (w >= 15) return '0;
        if (w == 8 || w == 9)
            return 32'h0140_0000 | (q.size() > 0 ? (32'h0001_0000 | 32'(q[0])) : 32'h0);
        if (w == 13) return m_raw;
        if (w == 14) return m_raw & st[11];
        return plain(w) ? st[w] : '0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle compare of registered outputs
    always @(negedge clk) begin
        if (!rst) begin
            check("R9 irq", {31'b0, irq}, {31'b0, |(m_raw & st[11])});
            check("R7 tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
            if (m_txv) check("R7 tx_byte", {24'b0, tx_byte}, {24'b0, m_txb});
        end
    end

    task automatic cyc(bit wr, bit rd, logic [5:0] a, logic [31:0] d, bit rv, logic [7:0] rb, string tag);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; rx_valid = rv; rx_byte = rb;
        #1;
        if (rd) begin
            logic [31:0] e = mread(a);
            if ((a[5:2] == 4'd8 || a[5:2] == 4'd9) && q.size() == 0)
                check(tag, reg_rdata & 32'hFFFF_FF00, e);
            else
                check(tag, reg_rdata, e);
        end
    endtask

    task automatic wr_reg(logic [5:0] a, logic [31:0] d, string tag);
        cyc(1, 0, a, d, 0, 8'h0, tag);
    endtask
    task automatic rd_reg(logic [5:0] a, string tag);
        cyc(0, 1, a, 32'h0, 0, 8'h0, tag);
    endtask
    task automatic rx(logic [7:0] b, string tag);
        cyc(0, 0, 6'h00, 32'h0, 1, b, tag);
    endtask
    task automatic idle();
        cyc(0, 0, 6'h00, 32'h0, 0, 8'h0, "idle");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset values
        rd_reg(6'h08, "R1 rxctl reset");
        check("R1 rxctl literal", reg_rdata, 32'h0001_0000);
        rd_reg(6'h24, "R1 status empty");
        check("R1 status literal", reg_rdata & 32'hFFFF_FF00, 32'h0140_0000);
        rd_reg(6'h34, "R1 raw clear");
        rd_reg(6'h2C, "R1 mask clear");

        // R5 reception disabled
        rx(8'h11, "R5 rx off");
        rd_reg(6'h24, "R5 nothing accepted");

        // enable reception, R3 peek vs pop, R2 format
        wr_reg(6'h08, 32'h0000_0008, "R5 enable");
        rx(8'hA1, "R4"); rx(8'hB2, "R4"); rx(8'hC3, "R4");
        rd_reg(6'h24, "R3 peek 1"); rd_reg(6'h24, "R3 peek 2");
        rd_reg(6'h20, "R2 pop oldest");
        rd_reg(6'h24, "R3 after pop");
        rd_reg(6'h20, "R3 pop"); rd_reg(6'h20, "R3 pop last");
        rd_reg(6'h20, "R3 pop empty");
        rd_reg(6'h24, "R3 empty after pops");

        // R6 raw bit 3 not updated by pop alone
        rd_reg(6'h34, "R6 stale raw bit3");
        check("R6 stale literal", reg_rdata & 32'h8, 32'h8);
        wr_reg(6'h10, 32'h0, "R6 recompute write");
        rd_reg(6'h34, "R6 raw after write");
        check("R6 cleared literal", reg_rdata & 32'h8, 32'h0);

        // R4 overflow and wrap
        for (int i = 0; i < 17; i++) rx(8'(8'h40 + i), "R4 fill");
        rd_reg(6'h34, "R4 raw while full");
        for (int i = 0; i < 16; i++) rd_reg(6'h20, "R4 drain order");
        rd_reg(6'h24, "R4 seventeenth dropped");

        // R11 pop and push together
        rx(8'h71, "R11"); rx(8'h72, "R11");
        cyc(0, 1, 6'h20, 32'h0, 1, 8'h73, "R11 pop+push");
        rd_reg(6'h20, "R11 order 1"); rd_reg(6'h20, "R11 order 2");
        rd_reg(6'h24, "R11 empty");

        // R7 transmit, R8 acknowledge, R9 mask
        wr_reg(6'h2C, 32'h0000_000F, "R9 mask");
        wr_reg(6'h1C, 32'h0000_01A5, "R7 dout");
        idle();
        rd_reg(6'h1C, "R7 dout stored");
        rd_reg(6'h34, "R7 raw bits");
        check("R7 raw literal", reg_rdata & 32'h3, 32'h3);
        rd_reg(6'h38, "R9 masked");
        wr_reg(6'h30, 32'h0000_0003, "R8 first ack");
        rd_reg(6'h34, "R8 bit0 kept");
        check("R8 bit0 literal", reg_rdata & 32'h3, 32'h1);
        rd_reg(6'h30, "R8 ack stored altered");
        wr_reg(6'h30, 32'h0000_0001, "R8 second ack");
        rd_reg(6'h34, "R8 bit0 cleared");
        wr_reg(6'h2C, 32'h0000_0002, "R9 mask 2");
        wr_reg(6'h1C, 32'h0000_005A, "R7 dout 2");
        rd_reg(6'h38, "R9 masked 2");
        wr_reg(6'h2C, 32'h0000_0000, "R9 mask off");
        rd_reg(6'h38, "R9 masked off");

        // R10 storage and ignored writes
        wr_reg(6'h0C, 32'hDEAD_BEEF, "R10"); rd_reg(6'h0C, "R10 word 0x0C");
        wr_reg(6'h28, 32'h1234_5678, "R10"); rd_reg(6'h28, "R10 word 0x28");
        wr_reg(6'h00, 32'h0000_00FF, "R10"); rd_reg(6'h00, "R10 word 0x00");
        wr_reg(6'h3C, 32'hFFFF_FFFF, "R10 outside"); rd_reg(6'h3C, "R10 outside reads 0");
        wr_reg(6'h24, 32'hFFFF_FFFF, "R10 status write"); rd_reg(6'h24, "R10 status unchanged");
        wr_reg(6'h38, 32'hFFFF_FFFF, "R10 masked write"); rd_reg(6'h38, "R10 masked unchanged");
        wr_reg(6'h34, 32'h0000_00F0, "R10 raw write"); rd_reg(6'h34, "R10 raw loaded");

        idle(); idle();
        finish_run();
    end

endmodule